// File: doc/BRIEF.md
# Extended Timebase with Deadline Compare

The block keeps system time in microseconds. A prescaler divides a whole-MHz clock down to one-microsecond steps. A narrow counter (16 bits by default) counts those steps, wraps freely over its full span, and is widened into a 64-bit absolute time that never wraps. Each time the sampled count is lower than the previous sample, the span of the counter is added to a base value.

One deadline, given as an absolute 64-bit time, can be pending. The block programs the low bits of a compare value and raises a one-cycle tick when the counter reaches that value. The compare target is always clamped to a window ahead of the current time: no closer than a minimum lead (50 µs by default) and no further than a maximum lead (50,000 µs by default). Because of the maximum lead, a tick occurs at least once per counter wrap, even with nothing pending. The applied compare value is an output, so a host can measure its own response latency against it.

Top module: `deadline_timebase`

## Requirements
- R1: The counter advances by exactly one every CLK_MHZ clock cycles. After reset it starts at 0.
- R2: `now_us` equals the number of completed counter wraps times 2^CNT_W, plus the counter value. It never decreases, and it grows by at most 1 per cycle.
- R3: While reset is active and right after it, `now_us` is 0, `tick` is low and `cmp_applied` is INIT_CMP.
- R4: `tick` is high for exactly the first clock cycle in which the counter holds a value equal to `cmp_applied`.
- R5: When a tick occurs and no deadline is pending, `cmp_applied` becomes the low CNT_W bits of now + LEAD_MAX, where now is the time in the tick cycle.
- R6: If the deadline is at or before now + LEAD_MIN, the compare value becomes the low bits of now + LEAD_MIN.
- R7: A deadline strictly between now + LEAD_MIN and now + LEAD_MAX gives its own low bits. A deadline at or beyond now + LEAD_MAX gives now + LEAD_MAX.
- R8: A cycle with `dl_load` high does three things at its closing edge: it sets the pending flag to `dl_valid`, it stores `dl_time`, and it recomputes `cmp_applied` from that cycle's now and inputs. A load with `dl_valid` low cancels any pending deadline, so the following ticks follow R5.
- R9: The deadline stops being pending at a tick whose now is at or after it. The recomputation at that tick then follows R5. A tick that occurs earlier keeps it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_time | input | 64 | Absolute deadline in µs |
| dl_valid | input | 1 | Deadline present (0 cancels) |
| dl_load | input | 1 | Strobe that applies dl_time/dl_valid |
| now_us | output | 64 | Extended absolute time in µs |
| tick | output | 1 | One-cycle compare-match pulse |
| cmp_applied | output | CNT_W | Compare value currently loaded |

## Verification
The counter and `now_us` change one edge after the prescaler's last cycle. `now_us` is combinational from the counter and base, so it is valid in that same cycle. `tick` rises in the first cycle that the new count matches and falls one cycle later. `cmp_applied` changes at the edge that closes a load or tick cycle, and is visible in the cycle after. The bench keeps a behavioural model in absolute microseconds and advances it at each rising edge with the same register count. It compares all three outputs on every falling edge. Each compare-value mismatch is tagged with the rule that produced the expected value.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int TIME_W = 64;
  typedef logic [TIME_W-1:0] abs_t;

  // Clamp a requested deadline into the window [now+lead_min, now+lead_max].
  function automatic abs_t pick_target(input abs_t now, input logic has_dl, input abs_t dl,
                                       input abs_t lead_min, input abs_t lead_max);
    abs_t lo;
    abs_t hi;
    lo = now + lead_min;
    hi = now + lead_max;
    if (!has_dl)   return hi;
    if (dl <= lo)  return lo;
    if (dl < hi)   return dl;
    return hi;
  endfunction

  // Deadline reached at the given time.
  function automatic logic is_due(input logic has_dl, input abs_t dl, input abs_t now);
    return has_dl && (dl <= now);
  endfunction
endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int CLK_MHZ = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_step
);
  localparam int PW = (CLK_MHZ > 2) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_MHZ - 1);

  logic [PW-1:0] div_q;

  assign us_step = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (us_step) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/us_counter.sv
module us_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_step,
  output logic [CNT_W-1:0] cnt,
  output logic             fresh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= us_step;
      if (us_step) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/time_extend.sv
module time_extend
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  output abs_t             now,
  output logic             wrapped
);
  localparam abs_t SPAN = abs_t'(1) << CNT_W;

  abs_t             base_q;
  abs_t             base_eff;
  logic [CNT_W-1:0] last_q;

  assign wrapped  = (cnt < last_q);
  assign base_eff = wrapped ? (base_q + SPAN) : base_q;
  assign now      = base_eff + abs_t'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
    end else begin
      base_q <= base_eff;
      last_q <= cnt;
    end
  end
endmodule

// File: rtl/deadline_timebase.sv
module deadline_timebase
  import tbase_pkg::*;
#(
  parameter int CLK_MHZ  = 8,
  parameter int CNT_W    = 16,
  parameter int LEAD_MIN = 50,
  parameter int LEAD_MAX = 50000,
  parameter int INIT_CMP = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      dl_time,
  input  logic             dl_valid,
  input  logic             dl_load,
  output logic [63:0]      now_us,
  output logic             tick,
  output logic [CNT_W-1:0] cmp_applied
);
  localparam abs_t MIN_A = abs_t'(LEAD_MIN);
  localparam abs_t MAX_A = abs_t'(LEAD_MAX);

  logic             us_step;
  logic [CNT_W-1:0] cnt;
  logic             fresh;
  logic             wrapped;
  abs_t             now;
  logic             pend_q;
  abs_t             dl_q;
  logic             dl_retire;
  logic             pend_next;
  abs_t             target_abs;
  logic [CNT_W-1:0] cmp_q;

  us_prescaler #(.CLK_MHZ(CLK_MHZ)) u_pre (
    .clk(clk), .rst_n(rst_n), .us_step(us_step)
  );

  us_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .us_step(us_step), .cnt(cnt), .fresh(fresh)
  );

  time_extend #(.CNT_W(CNT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .now(now), .wrapped(wrapped)
  );

  assign tick      = fresh && (cnt == cmp_q);
  assign dl_retire = tick && is_due(pend_q, dl_q, now);
  assign pend_next = pend_q && !dl_retire;

  always_comb begin
    if (dl_load) target_abs = pick_target(now, dl_valid, dl_time, MIN_A, MAX_A);
    else         target_abs = pick_target(now, pend_next, dl_q, MIN_A, MAX_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= CNT_W'(INIT_CMP);
      pend_q <= 1'b0;
      dl_q   <= '0;
    end else if (dl_load) begin
      pend_q <= dl_valid;
      dl_q   <= dl_time;
      cmp_q  <= target_abs[CNT_W-1:0];
    end else if (tick) begin
      pend_q <= pend_next;
      cmp_q  <= target_abs[CNT_W-1:0];
    end
  end

  assign now_us      = now;
  assign cmp_applied = cmp_q;
endmodule

// File: rtl/deadline_timebase_chk.sv
module deadline_timebase_chk #(
  parameter int CNT_W    = 16,
  parameter int LEAD_MIN = 50,
  parameter int LEAD_MAX = 50000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [63:0]      now_us,
  input logic             tick,
  input logic [CNT_W-1:0] cmp_applied,
  input logic [CNT_W-1:0] cnt,
  input logic             fresh,
  input logic             dl_load
);
  logic [CNT_W-1:0] prev_lo;
  logic [CNT_W-1:0] lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lo <= '0;
    else        prev_lo <= now_us[CNT_W-1:0];
  end

  assign lead = cmp_applied - prev_lo;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (cnt == $past(cnt) + 1'b1));

  assert_now_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (now_us >= $past(now_us)) && ((now_us - $past(now_us)) <= 64'd1));

  assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    now_us[CNT_W-1:0] == cnt);

  assert_tick_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt == cmp_applied));

  assert_tick_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6 and R7: every recomputed compare lies inside the lead window
  assert_lead_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) || $past(dl_load)) |->
      ((lead >= CNT_W'(LEAD_MIN)) && (lead <= CNT_W'(LEAD_MAX))));
endmodule

bind deadline_timebase deadline_timebase_chk #(
  .CNT_W(CNT_W), .LEAD_MIN(LEAD_MIN), .LEAD_MAX(LEAD_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .now_us(now_us), .tick(tick),
  .cmp_applied(cmp_applied), .cnt(cnt), .fresh(fresh), .dl_load(dl_load)
);

// File: tb/deadline_timebase_test.sv
`timescale 1ns/1ps
module deadline_timebase_test;
  localparam int CLK_MHZ = 2;
  localparam int CNT_W   = 10;
  localparam int LMIN    = 5;
  localparam int LMAX    = 600;
  localparam int INIT    = 100;
  localparam longint P   = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dl_time = '0;
  logic        dl_valid = 1'b0;
  logic        dl_load = 1'b0;
  logic [63:0] now_us;
  logic        tick;
  logic [CNT_W-1:0] cmp_applied;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit checking = 1'b0;

  // behavioural reference, absolute microseconds
  int     m_pre = 0;
  longint m_now = 0;
  bit     m_fresh = 0;
  longint m_cmp = INIT;
  bit     m_pend = 0;
  longint m_dl = 0;
  string  m_why = "R3";

  always #4 clk = ~clk;

  deadline_timebase #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W), .LEAD_MIN(LMIN),
                      .LEAD_MAX(LMAX), .INIT_CMP(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .dl_time(dl_time), .dl_valid(dl_valid),
    .dl_load(dl_load), .now_us(now_us), .tick(tick), .cmp_applied(cmp_applied)
  );

  function automatic longint target(longint now, bit has, longint dl, output string why);
    if (!has)               begin why = "R5"; return now + LMAX; end
    if (dl <= now + LMIN)   begin why = "R6"; return now + LMIN; end
    if (dl <  now + LMAX)   begin why = "R7"; return dl; end
    why = "R7";
    return now + LMAX;
  endfunction

  function automatic bit m_tick();
    return m_fresh && ((m_now % P) == m_cmp);
  endfunction

  always @(posedge clk) begin
    string w;
    bit t;
    if (!rst_n) begin
      m_pre = 0; m_now = 0; m_fresh = 0; m_cmp = INIT; m_pend = 0; m_dl = 0; m_why = "R3";
    end else begin
      t = m_tick();
      if (dl_load) begin
        m_pend = dl_valid;
        m_dl   = longint'(dl_time);
        m_cmp  = target(m_now, m_pend, m_dl, w) % P;
        m_why  = {"R8 ", w};
      end else if (t) begin
        if (m_pend && m_dl <= m_now) begin
          m_pend = 0;
          m_cmp  = target(m_now, m_pend, m_dl, w) % P;
          m_why  = {"R9 ", w};
        end else begin
          m_cmp  = target(m_now, m_pend, m_dl, w) % P;
          m_why  = w;
        end
      end
      if (m_pre == CLK_MHZ - 1) begin
        m_pre = 0; m_now = m_now + 1; m_fresh = 1;
      end else begin
        m_pre = m_pre + 1; m_fresh = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      check(longint'(now_us) == m_now, "R1 R2 now_us", longint'(now_us), m_now);
      check(tick == m_tick(), "R4 tick", longint'(tick), longint'(m_tick()));
      check(longint'(cmp_applied) == m_cmp, {m_why, " cmp_applied"}, longint'(cmp_applied), m_cmp);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input longint d, input bit v);
    @(negedge clk);
    dl_time = 64'(d); dl_valid = v; dl_load = 1'b1;
    @(negedge clk);
    dl_load = 1'b0;
  endtask

  initial begin
    idle(3);
    // R3: reset values while reset is held
    check(now_us == 64'd0, "R3 now during reset", longint'(now_us), 0);
    check(tick == 1'b0, "R3 tick during reset", longint'(tick), 0);
    check(cmp_applied == CNT_W'(INIT), "R3 cmp during reset", longint'(cmp_applied), INIT);
    rst_n = 1'b1;
    checking = 1'b1;
    // R1 R2 R5: free run over several wraps with nothing pending
    idle(5000);
    load(m_now + 200, 1'b1);      // R7 inside window
    idle(1200);
    load(m_now - 10, 1'b1);       // R6 already past
    idle(300);
    load(m_now + LMIN, 1'b1);     // R6 boundary, equal to min lead
    idle(300);
    load(m_now + LMIN + 1, 1'b1); // R7 just beyond min lead
    idle(300);
    load(m_now + LMAX - 1, 1'b1); // R7 just inside max lead
    idle(1600);
    load(m_now + LMAX, 1'b1);     // R7 boundary, clamped to max lead
    idle(2600);
    load(m_now + 3000, 1'b1);     // R9 far deadline survives early ticks
    idle(7000);
    load(m_now + 400, 1'b1);
    idle(100);
    load(m_now + 400, 1'b0);      // R8 cancel, ticks revert to max lead
    idle(3000);
    checking = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule